// File: doc/BRIEF.md
# Two-Channel Double-Buffered Converter Code Register

This block holds the digital code for two analog output channels. Each channel has two register ranks. A host write goes into the first (holding) rank of the channel that the write selects. The second (output) rank drives the converter. Each channel has its own mode bit, and that bit decides when the holding rank moves into the output rank.

In immediate mode a written value reaches the output one clock after the write is accepted. In timed mode the value stays in the holding rank until that channel's active-low load strobe is sampled low on a clock edge. Timed mode lets an external timing source update both converters at exact instants, whenever software wrote the data.

Each channel has a small transfer controller with two states. `XF_SYNCED` means the output rank equals the holding rank. `XF_PENDING` means the holding rank holds a value that has not reached the output yet. The transitions are:
- `T_WRITE`: a write to the channel, from either state, moves it to `XF_PENDING`.
- `T_XFER`: a transfer with no write in the same cycle moves it from `XF_PENDING` to `XF_SYNCED`.
- `T_XFER_WRITE`: a transfer together with a write keeps it in `XF_PENDING`.
- `T_RELOAD`: a strobe in `XF_SYNCED` in timed mode copies the same value again and stays in `XF_SYNCED`.

Top module: `dac_dual_rank_update`

## Requirements
- R1: When `rst_n` is low, the holding rank and the output rank of both channels are 0, so both `dac_code` fields read 0.
- R2: A write (`wr_en` high) stores `wr_data` only in the holding rank of channel `wr_ch` (0 selects channel 0, 1 selects channel 1). The other channel's output does not change.
- R3: In immediate mode (`mode_timed[c]`=0), a value written to channel c on clock edge k appears on `dac_code[c]` after edge k+1. It does not appear after edge k.
- R4: In timed mode (`mode_timed[c]`=1), `dac_code[c]` does not change on any edge where `load_n[c]` is sampled high. This holds however many writes take place.
- R5: In timed mode, on an edge where `load_n[c]` is sampled low, `dac_code[c]` takes the value the holding rank had before that edge. A write on the same edge goes only to the holding rank and waits for a later strobe.
- R6: A strobe with no write since the last transfer copies the same value again, and the output does not change.
- R7: The strobe of one channel never changes the other channel's output.
- R8: If a channel is switched from timed to immediate mode while a value is waiting in its holding rank, that value reaches the output on the first edge sampled in immediate mode.
- R9: In immediate mode the load strobe has no visible effect on the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all ranks update on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe, one write per cycle |
| wr_ch | input | CH_W (1) | Channel selected by the write |
| wr_data | input | DATA_W (12) | Code to store in the holding rank |
| mode_timed | input | NUM_CH (2) | Per-channel mode bit: 1 = timed, 0 = immediate |
| load_n | input | NUM_CH (2) | Per-channel active-low load strobe, sampled on the clock |
| dac_code | output | NUM_CH x DATA_W | Output-rank code of each channel, channel c in field c |

## Verification
Directed sequences cover the following cases:
- Immediate writes, to check that the output lags the write by exactly one edge.
- Timed writes held for several cycles and then strobed, to tell holding from transfer.
- A write that falls on the strobe edge, to show the strobe copies the old holding value.
- A strobe repeated with no new data, to show the output does not change.
- A strobe on one channel only, to show the channels are independent.
- A mode switch while a value is pending.

A seeded random phase then mixes writes, modes and strobes on both channels. A bench model, built from the requirements, predicts both outputs after every edge. The random phase can therefore catch ordering mistakes between write, strobe and mode that the directed cases do not reach.

// File: rtl/dac_upd_pkg.sv
package dac_upd_pkg;

    // Per-channel transfer controller states
    typedef enum logic {
        XF_SYNCED  = 1'b0,  // output rank equals holding rank
        XF_PENDING = 1'b1   // holding rank has a value not yet transferred
    } xfer_state_e;

    // Width of a channel index, at least one bit
    function automatic int chan_idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/dac_rank1_bank.sv
module dac_rank1_bank
    import dac_upd_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int NUM_CH = 2,
    localparam int CH_W  = chan_idx_w(NUM_CH)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [CH_W-1:0]                wr_ch,
    input  logic [DATA_W-1:0]              wr_data,
    output logic [NUM_CH-1:0]              wr_hit,
    output logic [NUM_CH-1:0][DATA_W-1:0]  hold_q
);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_hold
        // Decode the write to this channel
        always_comb begin
            wr_hit[g] = wr_en && (wr_ch == CH_W'(g));
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                hold_q[g] <= '0;
            end else if (wr_hit[g]) begin
                hold_q[g] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/dac_xfer_fsm.sv
module dac_xfer_fsm
    import dac_upd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_hit_i,
    input  logic timed_i,
    input  logic load_n_i,
    output logic xfer_o
);

    xfer_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= XF_SYNCED;
        end else begin
            state_q <= state_d;
        end
    end

    // Output: when the holding rank is copied into the output rank
    always_comb begin
        xfer_o = 1'b0;
        unique case (state_q)
            XF_SYNCED:  xfer_o = timed_i && !load_n_i;       // T_RELOAD
            XF_PENDING: xfer_o = timed_i ? !load_n_i : 1'b1; // T_XFER
            default:    xfer_o = 1'b0;
        endcase
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XF_SYNCED: begin
                if (wr_hit_i) state_d = XF_PENDING;               // T_WRITE
            end
            XF_PENDING: begin
                if (wr_hit_i)    state_d = XF_PENDING;            // T_XFER_WRITE / T_WRITE
                else if (xfer_o) state_d = XF_SYNCED;             // T_XFER
            end
            default: state_d = XF_SYNCED;
        endcase
    end

endmodule

// File: rtl/dac_rank2_reg.sv
module dac_rank2_reg #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_i,
    input  logic [DATA_W-1:0] d_i,
    output logic [DATA_W-1:0] q_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_o <= '0;
        end else if (xfer_i) begin
            q_o <= d_i;
        end
    end

endmodule

// File: rtl/dac_dual_rank_update.sv
module dac_dual_rank_update
    import dac_upd_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int NUM_CH = 2,
    localparam int CH_W  = chan_idx_w(NUM_CH)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [CH_W-1:0]                wr_ch,
    input  logic [DATA_W-1:0]              wr_data,
    input  logic [NUM_CH-1:0]              mode_timed,
    input  logic [NUM_CH-1:0]              load_n,
    output logic [NUM_CH-1:0][DATA_W-1:0]  dac_code
);

    logic [NUM_CH-1:0]             wr_hit;
    logic [NUM_CH-1:0][DATA_W-1:0] rank1;
    logic [NUM_CH-1:0]             xfer;

    dac_rank1_bank #(
        .DATA_W (DATA_W),
        .NUM_CH (NUM_CH)
    ) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_ch   (wr_ch),
        .wr_data (wr_data),
        .wr_hit  (wr_hit),
        .hold_q  (rank1)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        dac_xfer_fsm u_fsm (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_hit_i (wr_hit[g]),
            .timed_i  (mode_timed[g]),
            .load_n_i (load_n[g]),
            .xfer_o   (xfer[g])
        );

        dac_rank2_reg #(
            .DATA_W (DATA_W)
        ) u_out (
            .clk    (clk),
            .rst_n  (rst_n),
            .xfer_i (xfer[g]),
            .d_i    (rank1[g]),
            .q_o    (dac_code[g])
        );
    end

endmodule

// File: rtl/dac_upd_checker.sv
module dac_upd_checker
    import dac_upd_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int NUM_CH = 2,
    localparam int CH_W  = chan_idx_w(NUM_CH)
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           wr_en,
    input logic [CH_W-1:0]                wr_ch,
    input logic [DATA_W-1:0]              wr_data,
    input logic [NUM_CH-1:0]              mode_timed,
    input logic [NUM_CH-1:0]              load_n,
    input logic [NUM_CH-1:0][DATA_W-1:0]  dac_code,
    input logic [NUM_CH-1:0][DATA_W-1:0]  rank1
);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        // R1: output is zero on the first edge after reset release
        assert_reset_zero_R1: assert property (@(posedge clk)
            $rose(rst_n) |-> dac_code[g] == '0);

        // R3: immediate write appears one edge after acceptance
        assert_imm_lag_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_ch == CH_W'(g) && !mode_timed[g]) ##1 !mode_timed[g]
            |=> dac_code[g] == $past(wr_data, 2));

        // R4: timed mode with strobe high leaves the output untouched
        assert_timed_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(mode_timed[g]) && $past(load_n[g])) |-> $stable(dac_code[g]));

        // R5: strobe copies the pre-edge holding rank
        assert_load_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(mode_timed[g]) && !$past(load_n[g])) |-> dac_code[g] == $past(rank1[g]));
    end

endmodule

bind dac_dual_rank_update dac_upd_checker #(
    .DATA_W (DATA_W),
    .NUM_CH (NUM_CH)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_ch      (wr_ch),
    .wr_data    (wr_data),
    .mode_timed (mode_timed),
    .load_n     (load_n),
    .dac_code   (dac_code),
    .rank1      (rank1)
);

// File: tb/dac_dual_rank_update_tb.sv
module dac_dual_rank_update_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 12;
    localparam int NC = 2;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              wr_en;
    logic [0:0]        wr_ch;
    logic [DW-1:0]     wr_data;
    logic [NC-1:0]     mode_timed;
    logic [NC-1:0]     load_n;
    logic [NC-1:0][DW-1:0] dac_code;

    int n_checks = 0;
    int n_errors = 0;

    // Reference model state
    logic [DW-1:0] m_hold [NC];
    logic [DW-1:0] m_out  [NC];
    bit            m_pend [NC];

    always #(CLK_PERIOD/2) clk = ~clk;

    dac_dual_rank_update #(.DATA_W(DW), .NUM_CH(NC)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_ch      (wr_ch),
        .wr_data    (wr_data),
        .mode_timed (mode_timed),
        .load_n     (load_n),
        .dac_code   (dac_code)
    );

    task automatic check_val(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Model of one clock edge, taken from the requirements
    function automatic void model_edge();
        for (int c = 0; c < NC; c++) begin
            bit hit  = wr_en && (int'(wr_ch) == c);
            bit xfer = mode_timed[c] ? !load_n[c] : m_pend[c];
            if (xfer) m_out[c] = m_hold[c];
            if (hit) m_pend[c] = 1'b1;
            else if (xfer) m_pend[c] = 1'b0;
            if (hit) m_hold[c] = wr_data;
        end
    endfunction

    // Drive at the falling edge, run one rising edge, compare at the next falling edge
    task automatic step(input bit we, input int ch, input logic [DW-1:0] d,
                        input logic [NC-1:0] tm, input logic [NC-1:0] ln, input string tag);
        wr_en = we; wr_ch = 1'(ch); wr_data = d; mode_timed = tm; load_n = ln;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        for (int c = 0; c < NC; c++) check_val(dac_code[c], m_out[c], tag);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd7321));
        rst_n = 1'b0; wr_en = 1'b0; wr_ch = '0; wr_data = '0;
        mode_timed = '0; load_n = '1;
        for (int c = 0; c < NC; c++) begin m_hold[c] = '0; m_out[c] = '0; m_pend[c] = 1'b0; end
        repeat (3) @(negedge clk);
        check_val(dac_code[0], '0, "R1 ch0 in reset");
        check_val(dac_code[1], '0, "R1 ch1 in reset");
        rst_n = 1'b1;
        step(0, 0, '0, 2'b00, 2'b11, "R1 after release");

        // R3: immediate write on ch0, one edge of lag
        step(1, 0, 12'hABC, 2'b00, 2'b11, "R3 write edge");
        check_val(dac_code[0], 12'h000, "R3 not yet at write edge");
        step(0, 0, '0, 2'b00, 2'b11, "R3 following edge");
        check_val(dac_code[0], 12'hABC, "R3 value after one edge");
        check_val(dac_code[1], 12'h000, "R2 other channel untouched");

        // R4/R5: timed write on ch1, hold, then strobe
        step(1, 1, 12'h5A5, 2'b10, 2'b11, "R4 timed write");
        repeat (4) step(0, 0, '0, 2'b10, 2'b11, "R4 holding");
        check_val(dac_code[1], 12'h000, "R4 output held");
        step(0, 0, '0, 2'b10, 2'b01, "R5 strobe ch1");
        check_val(dac_code[1], 12'h5A5, "R5 value after strobe");

        // R5: write on the strobe edge copies the old holding value
        step(1, 1, 12'h777, 2'b10, 2'b01, "R5 write with strobe");
        check_val(dac_code[1], 12'h5A5, "R5 old value on shared edge");
        step(0, 0, '0, 2'b10, 2'b01, "R5 next strobe");
        check_val(dac_code[1], 12'h777, "R5 new value on next strobe");

        // R6: repeated strobes with no write
        repeat (3) step(0, 0, '0, 2'b10, 2'b01, "R6 reload");
        check_val(dac_code[1], 12'h777, "R6 output unchanged");

        // R7: strobe on ch0 while ch1 timed and pending
        step(1, 1, 12'h123, 2'b11, 2'b11, "R7 write ch1");
        step(0, 0, '0, 2'b11, 2'b10, "R7 strobe ch0 only");
        check_val(dac_code[1], 12'h777, "R7 ch1 unaffected");

        // R8: switch ch1 to immediate with value pending
        step(0, 0, '0, 2'b01, 2'b11, "R8 switch to immediate");
        check_val(dac_code[1], 12'h123, "R8 pending value delivered");

        // R9: strobe in immediate mode has no visible effect
        step(1, 0, 12'h0F0, 2'b00, 2'b00, "R9 write ch0 with strobe");
        step(0, 0, '0, 2'b00, 2'b00, "R9 strobe idle");
        check_val(dac_code[0], 12'h0F0, "R9 output follows write");

        // Random phase
        for (int i = 0; i < 600; i++) begin
            logic [NC-1:0] tm = 2'($urandom);
            logic [NC-1:0] ln = 2'($urandom);
            if ((i % 50) < 25) tm = '1;
            step(1'($urandom), int'($urandom % 2), 12'($urandom), tm, ln, "R2 random mix");
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule